// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain data lines, one on the host side and one on the card side. Both lines rest high through external pull-ups. The side whose line falls first becomes master. After a fixed propagation delay the block pulls the other side, the slave, low with a strong driver, so the master's logic 0 reaches the far end. While the master holds its line low, activity on the slave side is ignored. When the master lets its line go high, the block drives the slave side actively high for a short pulse so that the rising edge is fast. It then leaves both sides undriven again.

Each side gives the block one sampled line input and two drive controls: a strong pull-low and a brief push-high. One instance serves each data line of a card interface. An enable input from the activation sequencer selects between two conditions. When enable is high the repeater runs. When enable is low the card side is held low and the host side is left to its pull-up. A reference clock sets the propagation delay and the pulse width through counters. Both are parameters. With the defaults at a 100 MHz clock, the low copy arrives in 170 ns, the pulse lasts 100 ns, and one full transfer takes far less than the 1 µs period of 1 MHz line toggling.

Top module: `od_line_repeater`

## Requirements
- R1: While reset is asserted, cardPullLow is 1 and hostPullLow, hostPushHigh and cardPushHigh are 0.
- R2: With enable high and both lines high, no drive control is asserted and both lines stay high.
- R3: A host-side fall seen while idle asserts cardPullLow on rising edge SYNC_STAGES+DELAY_CYCLES+1, counted from the edge that first samples the low host line. With the defaults this is edge 17, or 170 ns at 100 MHz, which is within 200 ns.
- R4: A card-side fall seen while idle asserts hostPullLow with the same latency as R3.
- R5: When the master line returns high, the slave's pull-low drops and its push-high rises on edge SYNC_STAGES+1, counted from the edge that first samples the high line. The push-high lasts exactly PULSE_CYCLES cycles, and all drives are then off.
- R6: Slave-side edges that occur while the master owns the transfer do not change any drive control.
- R7: If both lines are first seen low on the same sampling edge, the host side becomes master.
- R8: If the master line goes high again before the delay expires, the slave side is never driven.
- R9: Enable low makes cardPullLow 1 and keeps both host drives 0 from the second rising edge on. This applies even in the middle of a transfer. Host edges have no effect while enable is low. Enable high releases the card side on the second edge, with no pulse.
- R10: At most one of the four drive controls is asserted in any cycle.
- R11: Back-to-back transfers at a 1 µs line period, with each line level held for 500 ns, are all repeated with the latencies of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for sampling and timing |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the card interface is active |
| hostLineIn | input | 1 | Sampled level of the host-side line |
| cardLineIn | input | 1 | Sampled level of the card-side line |
| hostPullLow | output | 1 | Strong low drive on the host-side line |
| hostPushHigh | output | 1 | Active-high pulse on the host-side line |
| cardPullLow | output | 1 | Strong low drive on the card-side line |
| cardPushHigh | output | 1 | Active-high pulse on the card-side line |

## Verification
Some properties are checked on every clock. These are: only one drive control is active at a time, and no push-high runs longer than its parameter. The ownership state holds while the master line stays low, whatever the slave does, and a tie hands ownership to the host. A disabled interface keeps the card side low and the host side free. Other behaviour can only be shown by the bench's scenarios with wired-AND line models. This covers the exact cycle at which each drive appears, the complete absence of a drive after a short glitch, release without a pulse after a mid-transfer disable, and correct repetition at a 1 MHz toggle rate.

// File: rtl/od_repeater_pkg.sv
package od_repeater_pkg;

  // Ownership state of the repeater
  typedef enum logic [2:0] {
    ST_OFF,     // interface inactive: card side held low
    ST_IDLE,    // both sides undriven, waiting for a first fall
    ST_HWAIT,   // host is master, propagation delay running
    ST_HHOLD,   // card side pulled low while host stays low
    ST_HPULSE,  // card side pushed high after host release
    ST_CWAIT,   // card is master, propagation delay running
    ST_CHOLD,   // host side pulled low while card stays low
    ST_CPULSE   // host side pushed high after card release
  } repState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadDelay;
    logic loadPulse;
    logic hostLow;
    logic hostHigh;
    logic cardLow;
    logic cardHigh;
  } repStrobe_t;

  localparam int SIDE_HOST = 0;
  localparam int SIDE_CARD = 1;
  localparam int SIDE_COUNT = 2;

endpackage

// File: rtl/od_edge_sync.sv
module od_edge_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineSync,
  output logic lineFall
);

  logic [STAGES-1:0] shReg;
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= {STAGES{RESET_VAL}};
      prevQ <= RESET_VAL;
    end else begin
      shReg <= {shReg[STAGES-2:0], lineIn};
      prevQ <= shReg[STAGES-1];
    end
  end

  assign lineSync = shReg[STAGES-1];
  assign lineFall = prevQ & ~lineSync;

endmodule

// File: rtl/od_repeater_dp.sv
module od_repeater_dp
  import od_repeater_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_CYCLES = 14,
  parameter int PULSE_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostLineIn,
  input  logic       cardLineIn,
  input  repStrobe_t strobe,
  output logic       hostHigh,
  output logic       cardHigh,
  output logic       hostFall,
  output logic       cardFall,
  output logic       cntZero,
  output logic       hostPullLow,
  output logic       hostPushHigh,
  output logic       cardPullLow,
  output logic       cardPushHigh
);

  localparam int CNT_MAX = (DELAY_CYCLES > PULSE_CYCLES) ? DELAY_CYCLES : PULSE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(DELAY_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES - 1);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

  // Input synchronisers, one per side
  logic [SIDE_COUNT-1:0] lineRaw;
  logic [SIDE_COUNT-1:0] lineSyncV;
  logic [SIDE_COUNT-1:0] lineFallV;

  assign lineRaw[SIDE_HOST] = hostLineIn;
  assign lineRaw[SIDE_CARD] = cardLineIn;

  for (genvar s = 0; s < SIDE_COUNT; s++) begin : g_side
    // host idles high; card is held low by the inactive state
    od_edge_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(s == SIDE_HOST)
    ) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (lineRaw[s]),
      .lineSync(lineSyncV[s]),
      .lineFall(lineFallV[s])
    );
  end

  assign hostHigh = lineSyncV[SIDE_HOST];
  assign cardHigh = lineSyncV[SIDE_CARD];
  assign hostFall = lineFallV[SIDE_HOST];
  assign cardFall = lineFallV[SIDE_CARD];

  // Shared timer for delay and pulse
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadDelay) begin
      cnt <= DELAY_LOAD;
    end else if (strobe.loadPulse) begin
      cnt <= PULSE_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // Registered drive controls
  logic [3:0] drvQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvQ <= 4'b0010;
    end else begin
      drvQ <= {strobe.hostLow, strobe.hostHigh, strobe.cardLow, strobe.cardHigh};
    end
  end

  assign hostPullLow  = drvQ[3];
  assign hostPushHigh = drvQ[2];
  assign cardPullLow  = drvQ[1];
  assign cardPushHigh = drvQ[0];

  // Length of the current push-high run
  logic [RUN_W-1:0] pushRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushRun <= '0;
    end else if (hostPushHigh || cardPushHigh) begin
      pushRun <= pushRun + 1'b1;
    end else begin
      pushRun <= '0;
    end
  end

  AST_SINGLE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hostPullLow, hostPushHigh, cardPullLow, cardPushHigh}) <= 1); // R10

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pushRun <= RUN_W'(PULSE_CYCLES)); // R5

endmodule

// File: rtl/od_repeater_ctrl.sv
module od_repeater_ctrl
  import od_repeater_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       hostHigh,
  input  logic       cardHigh,
  input  logic       hostFall,
  input  logic       cardFall,
  input  logic       cntZero,
  output repStrobe_t strobe
);

  repState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_OFF:   strobe.cardLow  = 1'b1;
      ST_HHOLD: strobe.cardLow  = 1'b1;
      ST_HPULSE: strobe.cardHigh = 1'b1;
      ST_CHOLD: strobe.hostLow  = 1'b1;
      ST_CPULSE: strobe.hostHigh = 1'b1;
      default: ;
    endcase
    if (!enable) begin
      stateNext = ST_OFF;
    end else begin
      case (state)
        ST_OFF: stateNext = ST_IDLE;
        ST_IDLE: begin
          if (hostFall) begin        // host wins a tie
            stateNext        = ST_HWAIT;
            strobe.loadDelay = 1'b1;
          end else if (cardFall) begin
            stateNext        = ST_CWAIT;
            strobe.loadDelay = 1'b1;
          end
        end
        ST_HWAIT: begin
          if (hostHigh)     stateNext = ST_IDLE;
          else if (cntZero) stateNext = ST_HHOLD;
        end
        ST_HHOLD: begin
          if (hostHigh) begin
            stateNext        = ST_HPULSE;
            strobe.loadPulse = 1'b1;
          end
        end
        ST_HPULSE: if (cntZero) stateNext = ST_IDLE;
        ST_CWAIT: begin
          if (cardHigh)     stateNext = ST_IDLE;
          else if (cntZero) stateNext = ST_CHOLD;
        end
        ST_CHOLD: begin
          if (cardHigh) begin
            stateNext        = ST_CPULSE;
            strobe.loadPulse = 1'b1;
          end
        end
        ST_CPULSE: if (cntZero) stateNext = ST_IDLE;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_HHOLD && !hostHigh) |=> (state == ST_HHOLD)); // R6

  AST_CARD_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_CHOLD && !cardHigh) |=> (state == ST_CHOLD)); // R6

  AST_TIE_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_IDLE && hostFall && cardFall) |=> (state == ST_HWAIT)); // R7

endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
  import od_repeater_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_CYCLES = 14,
  parameter int PULSE_CYCLES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic hostLineIn,
  input  logic cardLineIn,
  output logic hostPullLow,
  output logic hostPushHigh,
  output logic cardPullLow,
  output logic cardPushHigh
);

  repStrobe_t strobe;
  logic hostHigh, cardHigh, hostFall, cardFall, cntZero;

  od_repeater_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .hostHigh(hostHigh),
    .cardHigh(cardHigh),
    .hostFall(hostFall),
    .cardFall(cardFall),
    .cntZero (cntZero),
    .strobe  (strobe)
  );

  od_repeater_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .DELAY_CYCLES(DELAY_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostLineIn  (hostLineIn),
    .cardLineIn  (cardLineIn),
    .strobe      (strobe),
    .hostHigh    (hostHigh),
    .cardHigh    (cardHigh),
    .hostFall    (hostFall),
    .cardFall    (cardFall),
    .cntZero     (cntZero),
    .hostPullLow (hostPullLow),
    .hostPushHigh(hostPushHigh),
    .cardPullLow (cardPullLow),
    .cardPushHigh(cardPushHigh)
  );

  AST_OFF_CARD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable, 2) |-> cardPullLow); // R9

  AST_OFF_HOST_FREE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable, 2) |-> (!hostPullLow && !hostPushHigh)); // R9

endmodule

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC  = 2;
  localparam int DLY   = 14;
  localparam int PLS   = 10;
  localparam int LAT   = SYNC + DLY + 1;
  localparam int REL   = SYNC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic hostDev = 1'b1;
  logic cardDev = 1'b1;
  logic hostLine, cardLine;
  logic hostPullLow, hostPushHigh, cardPullLow, cardPushHigh;
  logic [3:0] vec;
  logic [3:0] prevVec;
  logic monOn = 1'b0;
  logic done = 1'b0;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int cycle;
    logic [3:0] value;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND line models
  assign hostLine = hostDev & ~hostPullLow;
  assign cardLine = cardDev & ~cardPullLow;
  assign vec = {hostPullLow, hostPushHigh, cardPullLow, cardPushHigh};

  od_line_repeater #(
    .SYNC_STAGES (SYNC),
    .DELAY_CYCLES(DLY),
    .PULSE_CYCLES(PLS)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .hostLineIn  (hostLine),
    .cardLineIn  (cardLine),
    .hostPullLow (hostPullLow),
    .hostPushHigh(hostPushHigh),
    .cardPullLow (cardPullLow),
    .cardPushHigh(cardPushHigh)
  );

  // Monitor: every change of the drive vector must match the queue head
  always @(negedge clk) begin
    if (monOn && vec !== prevVec) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected change cycle=%0d actual=%b expected=%b (no pending item)", cyc, vec, prevVec);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.cycle != cyc || e.value !== vec) begin
          failures++;
          $display("FAIL %s actual=%b@%0d expected=%b@%0d", e.tag, vec, cyc, e.value, e.cycle);
        end
      end
      checks++;
      if ($countones(vec) > 1) begin
        failures++;
        $display("FAIL R10 actual=%b expected at most one drive", vec);
      end
    end
    prevVec = vec;
  end

  task automatic expectAt(int c, logic [3:0] v, string tag);
    exp_t e;
    e.cycle = c;
    e.value = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic checkVec(logic [3:0] v, string tag);
    checks++;
    if (vec !== v) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, vec, v);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostFallT(string tag);
    int c0;
    @(negedge clk);
    hostDev = 1'b0;
    c0 = cyc + 1;
    expectAt(c0 + LAT, 4'b0010, tag);
  endtask

  task automatic hostReleaseT(string tag);
    int c0;
    @(negedge clk);
    hostDev = 1'b1;
    c0 = cyc + 1;
    expectAt(c0 + REL, 4'b0001, tag);
    expectAt(c0 + REL + PLS, 4'b0000, tag);
  endtask

  task automatic cardFallT(string tag);
    int c0;
    @(negedge clk);
    cardDev = 1'b0;
    c0 = cyc + 1;
    expectAt(c0 + LAT, 4'b1000, tag);
  endtask

  task automatic cardReleaseT(string tag);
    int c0;
    @(negedge clk);
    cardDev = 1'b1;
    c0 = cyc + 1;
    expectAt(c0 + REL, 4'b0100, tag);
    expectAt(c0 + REL + PLS, 4'b0000, tag);
  endtask

  task automatic setEnable(logic v, logic [3:0] expVal, string tag);
    int c0;
    @(negedge clk);
    enable = v;
    c0 = cyc + 1;
    expectAt(c0 + 1, expVal, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state
    waitCyc(3);
    checkVec(4'b0010, "R1");
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    waitCyc(3);
    setEnable(1'b1, 4'b0000, "R9 enable");
    waitCyc(30);

    // R2: idle
    checkVec(4'b0000, "R2");
    checks++;
    if (!(hostLine && cardLine)) begin
      failures++;
      $display("FAIL R2 actual=%b%b expected=11", hostLine, cardLine);
    end

    // R3, R5: host-mastered transfer
    hostFallT("R3");
    waitCyc(40);
    hostReleaseT("R5 host");
    waitCyc(30);

    // R4, R5: card-mastered transfer
    cardFallT("R4");
    waitCyc(40);
    cardReleaseT("R5 card");
    waitCyc(30);

    // R8: glitches shorter than the delay
    @(negedge clk);
    hostDev = 1'b0;
    waitCyc(3);
    hostDev = 1'b1;
    waitCyc(30);
    @(negedge clk);
    cardDev = 1'b0;
    waitCyc(3);
    cardDev = 1'b1;
    waitCyc(30);
    checkVec(4'b0000, "R8");
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R8 actual=%0d pending expected=0", expQ.size());
    end

    // R6: card edges while host owns the transfer
    hostFallT("R6");
    waitCyc(3);
    cardDev = 1'b0;
    waitCyc(20);
    cardDev = 1'b1;
    waitCyc(10);
    cardDev = 1'b0;
    waitCyc(3);
    cardDev = 1'b1;
    waitCyc(10);
    hostReleaseT("R6 release");
    waitCyc(30);

    // R7: simultaneous falls
    begin
      int c0;
      @(negedge clk);
      hostDev = 1'b0;
      cardDev = 1'b0;
      c0 = cyc + 1;
      expectAt(c0 + LAT, 4'b0010, "R7");
    end
    waitCyc(40);
    begin
      int c0;
      @(negedge clk);
      hostDev = 1'b1;
      cardDev = 1'b1;
      c0 = cyc + 1;
      expectAt(c0 + REL, 4'b0001, "R7 release");
      expectAt(c0 + REL + PLS, 4'b0000, "R7 release");
    end
    waitCyc(30);

    // R11: 1 MHz toggling, 50 cycles per level
    for (int i = 0; i < 5; i++) begin
      hostFallT("R11");
      waitCyc(49);
      hostReleaseT("R11");
      waitCyc(49);
    end
    waitCyc(20);

    // R9: disable while idle, host edges ignored
    setEnable(1'b0, 4'b0010, "R9 disable");
    waitCyc(10);
    hostDev = 1'b0;
    waitCyc(30);
    checkVec(4'b0010, "R9 host ignored");
    hostDev = 1'b1;
    waitCyc(10);
    setEnable(1'b1, 4'b0000, "R9 re-enable");
    waitCyc(20);

    // R9: disable in the middle of a transfer, no pulse afterwards
    hostFallT("R9 mid");
    waitCyc(30);
    @(negedge clk);
    enable = 1'b0;
    waitCyc(5);
    hostDev = 1'b1;
    waitCyc(30);
    checkVec(4'b0010, "R9 mid hold");
    setEnable(1'b1, 4'b0000, "R9 mid release");
    waitCyc(30);
    checkVec(4'b0000, "R9 no pulse");

    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R3 pending items actual=%0d expected=0", expQ.size());
    end
    finishRun();
  end

endmodule